// File: doc/BRIEF.md
# Memory-Mapped Select and Handshake Unit

This block stands between one bus master and five memory-mapped targets: a low and a high SRAM window, a low and a high ROM window, and one EEPROM window, each 8 KB. The master presents a 16-bit address, a read or write strobe, a size bit (byte or 16-bit word) and write data. The block registers the request, decides which target owns the address, drives exactly one active-high select for one cycle together with the in-window offset, byte enables and write data, gathers the read data of the selected target, and then gives the master a single-cycle ready pulse. Requests that cannot be served (no owner, a write to ROM, a misaligned word) raise an error with ready instead, and no select is driven.

The parameter `PARTIAL` picks the decoder variant. With `PARTIAL = 0` the three tag bits A15..A13 must equal a window's tag exactly, so the three gaps in the map are unmapped. With `PARTIAL = 1` each target tests only the bits that set it apart from the others, so the gaps alias onto neighbouring targets and no address is unmapped.

The controller runs four states. `ST_IDLE` waits for a strobe; on a strobe it goes to `ST_ACCESS` for a servable request or to `ST_FAULT` otherwise. `ST_ACCESS` drives the select for one cycle and captures the target's data, then moves to `ST_REPLY`, which pulses ready and returns to `ST_IDLE`. `ST_FAULT` pulses ready with the error flag and returns to `ST_IDLE`.

Top module: `memmap_decoder`

## Requirements
- R1: With `PARTIAL = 0`, the tag A15..A13 selects targets as 001 → select bit 0 (SRAM low), 010 → bit 1 (ROM low), 011 → bit 2 (EEPROM), 101 → bit 3 (SRAM high), 110 → bit 4 (ROM high).
- R2: With `PARTIAL = 0`, tags 000, 100 and 111 are unmapped: no select is driven, ready and error are high in the cycle after the accepting edge, and read data is all ones then.
- R3: With `PARTIAL = 1`, tag 000 aliases to bit 0, 100 to bit 3 and 111 to bit 2, the other tags select as in R1, and no aligned read ever reports an error.
- R4: At most one select bit is high in any cycle, and a select stays high for exactly one cycle per request.
- R5: A served read drives its select in the cycle after the accepting edge and ready, with error low and the read data, in the following cycle.
- R6: A served write to SRAM or EEPROM drives the select with the write enable high and the write data in the cycle after the accepting edge; ready follows one cycle later with error low.
- R7: A write to either ROM window drives no select and no write enable and completes as a fault with the timing of R2.
- R8: Ready is high for exactly one cycle per request, and strobes that arrive while a request is outstanding are ignored.
- R9: Byte access: enables are 01 for an even address and 10 for an odd one, write data carries the byte on both lanes, and read data is the addressed byte in bits 7..0 with bits 15..8 zero. Word access: enables are 11 and data passes unchanged.
- R10: A word access at an odd address is a fault with the timing of R2 and drives no select.
- R11: While a select is high, the offset output equals address bits 12..0 of the request.
- R12: After reset the block is idle: no select, ready low, error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Request address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe (wins if both are high) |
| bus_word_i | input | 1 | Size: 1 = 16-bit word, 0 = byte |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid with ready |
| bus_ready_o | output | 1 | One-cycle completion pulse |
| bus_err_o | output | 1 | Fault flag, high with ready |
| dev_sel_o | output | 5 | One-hot target select |
| dev_offs_o | output | 13 | Offset inside the selected window |
| dev_we_o | output | 1 | Write enable to the selected target |
| dev_be_o | output | 2 | Byte lane enables |
| dev_wdata_o | output | 16 | Write data toward the targets |
| dev_rdata_i | input | 80 | Read data of all targets, target k in bits 16k+15..16k |

## Verification
The hardest situation to create from the ports is a strobe that lands while a request is outstanding, because the master normally waits for ready. The bench re-raises a strobe during the select or fault cycle of chosen transfers and checks that neither a second select nor a second ready appears. The gap addresses are the other subtle point: a full-decode and a partial-decode instance receive the same random and directed traffic side by side, so every gap address is seen faulting in one and aliasing in the other.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;

    localparam int NUM_DEV = 5;
    localparam int TAG_W   = 3;

    typedef enum logic [2:0] {
        DEV_SRAM_LO = 3'd0,
        DEV_ROM_LO  = 3'd1,
        DEV_NVM     = 3'd2,
        DEV_SRAM_HI = 3'd3,
        DEV_ROM_HI  = 3'd4,
        DEV_NONE    = 3'd5
    } dev_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_REPLY  = 2'd2,
        ST_FAULT  = 2'd3
    } state_e;

    // exact tag for each window, indexed by dev_e value
    localparam logic [TAG_W-1:0] FULL_TAG [NUM_DEV] =
        '{3'b001, 3'b010, 3'b011, 3'b101, 3'b110};

    // reduced decode: bits that take part, and the value they must have
    localparam logic [TAG_W-1:0] PART_MASK [NUM_DEV] =
        '{3'b110, 3'b111, 3'b011, 3'b110, 3'b111};
    localparam logic [TAG_W-1:0] PART_VAL [NUM_DEV] =
        '{3'b000, 3'b010, 3'b011, 3'b100, 3'b110};

    function automatic logic dev_is_rom(input dev_e d);
        return (d == DEV_ROM_LO) || (d == DEV_ROM_HI);
    endfunction

endpackage

// File: rtl/mmdec_region_match.sv
module mmdec_region_match
    import mmdec_pkg::*;
#(
    parameter bit PARTIAL = 1'b0
) (
    input  logic [TAG_W-1:0] tag_i,
    output dev_e             dev_o
);

    logic [NUM_DEV-1:0] hit;

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_dev
        if (PARTIAL) begin : g_part
            assign hit[k] = ((tag_i ^ PART_VAL[k]) & PART_MASK[k]) == '0;
        end else begin : g_full
            assign hit[k] = (tag_i == FULL_TAG[k]);
        end
    end

    // hits are disjoint by table construction; the loop only encodes
    always_comb begin
        dev_o = DEV_NONE;
        for (int k = NUM_DEV - 1; k >= 0; k--) begin
            if (hit[k]) dev_o = dev_e'(3'(k));
        end
    end

endmodule

// File: rtl/mmdec_lanes.sv
module mmdec_lanes #(
    parameter int DATA_W = 16,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              word_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] slot_rdata_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = slot_rdata_i >> {lane_i, 3'b000};
        if (word_i) begin
            be_o    = '1;
            wdata_o = wdata_i;
            rdata_o = slot_rdata_i;
        end else begin
            be_o    = LANES'(1) << lane_i;
            wdata_o = {LANES{wdata_i[7:0]}};
            rdata_o = {{(DATA_W-8){1'b0}}, shifted[7:0]};
        end
    end

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import mmdec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter bit PARTIAL = 1'b0,
    localparam int OFFS_W = ADDR_W - TAG_W,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic                      bus_rd_i,
    input  logic                      bus_wr_i,
    input  logic                      bus_word_i,
    input  logic [DATA_W-1:0]         bus_wdata_i,
    output logic [DATA_W-1:0]         bus_rdata_o,
    output logic                      bus_ready_o,
    output logic                      bus_err_o,
    output logic [NUM_DEV-1:0]        dev_sel_o,
    output logic [OFFS_W-1:0]         dev_offs_o,
    output logic                      dev_we_o,
    output logic [LANES-1:0]          dev_be_o,
    output logic [DATA_W-1:0]         dev_wdata_o,
    input  logic [NUM_DEV*DATA_W-1:0] dev_rdata_i
);

    state_e state_q, state_d;

    dev_e              req_dev;
    logic              accept;
    logic              misaligned;
    logic              refuse;

    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic              word_q;
    logic [DATA_W-1:0] wdata_q;
    dev_e              dev_q;
    logic [DATA_W-1:0] rdata_q;

    logic [DATA_W-1:0] slot_rdata;
    logic [DATA_W-1:0] lane_rdata;
    logic [DATA_W-1:0] lane_wdata;
    logic [LANES-1:0]  lane_be;

    mmdec_region_match #(.PARTIAL(PARTIAL)) u_match (
        .tag_i (bus_addr_i[ADDR_W-1:OFFS_W]),
        .dev_o (req_dev)
    );

    assign accept     = (state_q == ST_IDLE) && (bus_rd_i || bus_wr_i);
    assign misaligned = bus_word_i && (bus_addr_i[LANE_W-1:0] != '0);
    assign refuse     = (req_dev == DEV_NONE)
                     || (bus_wr_i && dev_is_rom(req_dev))
                     || misaligned;

    // data of the target held in dev_q
    always_comb begin
        slot_rdata = '0;
        for (int k = 0; k < NUM_DEV; k++) begin
            if (dev_q == dev_e'(3'(k))) slot_rdata = dev_rdata_i[k*DATA_W +: DATA_W];
        end
    end

    mmdec_lanes #(.DATA_W(DATA_W)) u_lanes (
        .word_i       (word_q),
        .lane_i       (addr_q[LANE_W-1:0]),
        .wdata_i      (wdata_q),
        .slot_rdata_i (slot_rdata),
        .be_o         (lane_be),
        .wdata_o      (lane_wdata),
        .rdata_o      (lane_rdata)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = refuse ? ST_FAULT : ST_ACCESS;
            end
            ST_ACCESS: state_d = ST_REPLY;
            ST_REPLY:  state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            word_q  <= 1'b0;
            wdata_q <= '0;
            dev_q   <= DEV_NONE;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= bus_addr_i;
                wr_q    <= bus_wr_i;
                word_q  <= bus_word_i;
                wdata_q <= bus_wdata_i;
                dev_q   <= req_dev;
            end
            if (state_q == ST_ACCESS) begin
                rdata_q <= wr_q ? '0 : lane_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        bus_rdata_o = '0;
        bus_ready_o = 1'b0;
        bus_err_o   = 1'b0;
        dev_sel_o   = '0;
        dev_we_o    = 1'b0;
        dev_be_o    = '0;
        dev_offs_o  = addr_q[OFFS_W-1:0];
        dev_wdata_o = lane_wdata;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ACCESS: begin
                dev_sel_o = NUM_DEV'(1) << dev_q;
                dev_we_o  = wr_q;
                dev_be_o  = lane_be;
            end
            ST_REPLY: begin
                bus_ready_o = 1'b1;
                bus_rdata_o = rdata_q;
            end
            ST_FAULT: begin
                bus_ready_o = 1'b1;
                bus_err_o   = 1'b1;
                bus_rdata_o = '1;
            end
        endcase
    end

endmodule

// File: rtl/memmap_decoder_checker.sv
module memmap_decoder_checker
    import mmdec_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               bus_ready_o,
    input logic               bus_err_o,
    input logic [NUM_DEV-1:0] dev_sel_o,
    input logic               dev_we_o,
    input logic [LANES-1:0]   dev_be_o
);

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel_o));

    assert_sel_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_sel_o) |=> (dev_sel_o == '0));

    assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready_o |=> !bus_ready_o);

    assert_select_then_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_sel_o) |=> (bus_ready_o && !bus_err_o));

    assert_fault_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (bus_ready_o && (dev_sel_o == '0) && (bus_rdata_o == '1)));

    assert_rom_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel_o[1] || dev_sel_o[4]) |-> !dev_we_o);

    assert_we_with_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we_o |-> (|dev_sel_o));

    assert_be_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_sel_o) |-> (($countones(dev_be_o) == 1) || (dev_be_o == '1)));

endmodule

bind memmap_decoder memmap_decoder_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rdata_o (bus_rdata_o),
    .bus_ready_o (bus_ready_o),
    .bus_err_o   (bus_err_o),
    .dev_sel_o   (dev_sel_o),
    .dev_we_o    (dev_we_o),
    .dev_be_o    (dev_be_o)
);

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic        word = 1'b0;
    logic [15:0] wdata = '0;

    logic [15:0] rdata_w [2];
    logic        rdy_w   [2];
    logic        err_w   [2];
    logic [4:0]  sel_w   [2];
    logic [12:0] offs_w  [2];
    logic        we_w    [2];
    logic [1:0]  be_w    [2];
    logic [15:0] dwd_w   [2];
    logic [79:0] drd_w   [2];

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    // behavioural target data: depends on target index and offset
    function automatic logic [15:0] stub(input int k, input logic [12:0] offs);
        return 16'((k + 1) * 16'h1111) ^ {3'b000, offs};
    endfunction

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            for (int k = 0; k < 5; k++) drd_w[i][k*16 +: 16] = stub(k, offs_w[i]);
        end
    end

    memmap_decoder #(.PARTIAL(1'b0)) u_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata_w[0]),
        .bus_ready_o(rdy_w[0]), .bus_err_o(err_w[0]), .dev_sel_o(sel_w[0]),
        .dev_offs_o(offs_w[0]), .dev_we_o(we_w[0]), .dev_be_o(be_w[0]),
        .dev_wdata_o(dwd_w[0]), .dev_rdata_i(drd_w[0]));

    memmap_decoder #(.PARTIAL(1'b1)) u_memmap_decoder_alias (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata_w[1]),
        .bus_ready_o(rdy_w[1]), .bus_err_o(err_w[1]), .dev_sel_o(sel_w[1]),
        .dev_offs_o(offs_w[1]), .dev_we_o(we_w[1]), .dev_be_o(be_w[1]),
        .dev_wdata_o(dwd_w[1]), .dev_rdata_i(drd_w[1]));

    // expected owner: 0..4 target index, 5 none
    function automatic int exp_dev(input logic [15:0] a, input bit partial);
        if (!partial) begin
            if (a >= 16'h2000 && a <= 16'h3FFF) return 0;
            if (a >= 16'h4000 && a <= 16'h5FFF) return 1;
            if (a >= 16'h6000 && a <= 16'h7FFF) return 2;
            if (a >= 16'hA000 && a <= 16'hBFFF) return 3;
            if (a >= 16'hC000 && a <= 16'hDFFF) return 4;
            return 5;
        end
        case (a[15:13])
            3'b000, 3'b001: return 0;
            3'b010:         return 1;
            3'b011, 3'b111: return 2;
            3'b100, 3'b101: return 3;
            default:        return 4;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic txn(input logic [15:0] a, input bit w, input bit wd_word,
                       input logic [15:0] wd, input bit poke);
        int    dv   [2];
        bit    flt  [2];
        logic [15:0] xrd;
        logic [15:0] sv;
        for (int i = 0; i < 2; i++) begin
            dv[i]  = exp_dev(a, i == 1);
            flt[i] = (dv[i] == 5) || (w && (dv[i] == 1 || dv[i] == 4)) || (wd_word && a[0]);
        end
        @(negedge clk);
        addr = a; rd = !w; wr = w; word = wd_word; wdata = wd;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        for (int i = 0; i < 2; i++) begin
            if (flt[i]) begin
                chk(sel_w[i] == 5'd0, "R2/R7/R10 no select on fault", 32'(sel_w[i]), 0);
                chk(we_w[i] == 1'b0, "R7 no write enable on fault", 32'(we_w[i]), 0);
                chk(rdy_w[i] && err_w[i], "R2 fault ready+error", {rdy_w[i], err_w[i]}, 3);
                chk(rdata_w[i] == 16'hFFFF, "R2 fault data all ones", 32'(rdata_w[i]), 32'hFFFF);
            end else begin
                chk(sel_w[i] == 5'(1 << dv[i]), "R1/R3 select", 32'(sel_w[i]), 32'(1 << dv[i]));
                chk(offs_w[i] == a[12:0], "R11 offset", 32'(offs_w[i]), 32'(a[12:0]));
                chk(we_w[i] == w, "R6 write enable", 32'(we_w[i]), 32'(w));
                chk(be_w[i] == (wd_word ? 2'b11 : (a[0] ? 2'b10 : 2'b01)), "R9 byte enables",
                    32'(be_w[i]), 32'(wd_word ? 2'b11 : (a[0] ? 2'b10 : 2'b01)));
                if (w) chk(dwd_w[i] == (wd_word ? wd : {wd[7:0], wd[7:0]}), "R6/R9 write data",
                           32'(dwd_w[i]), 32'(wd_word ? wd : {wd[7:0], wd[7:0]}));
                chk(rdy_w[i] == 1'b0, "R5 no ready with select", 32'(rdy_w[i]), 0);
            end
        end
        if (poke) begin
            addr = 16'hC000; rd = 1'b1;
        end
        @(negedge clk);
        rd = 1'b0;
        for (int i = 0; i < 2; i++) begin
            chk(sel_w[i] == 5'd0, "R4/R8 no select after access", 32'(sel_w[i]), 0);
            if (flt[i]) begin
                chk(rdy_w[i] == 1'b0, "R8 single ready on fault", 32'(rdy_w[i]), 0);
            end else begin
                chk(rdy_w[i] && !err_w[i], "R5/R6 ready without error", {rdy_w[i], err_w[i]}, 2);
                if (!w) begin
                    sv  = stub(dv[i], a[12:0]);
                    xrd = wd_word ? sv : {8'h00, (a[0] ? sv[15:8] : sv[7:0])};
                    chk(rdata_w[i] == xrd, "R5/R9 read data", 32'(rdata_w[i]), 32'(xrd));
                end
            end
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(rdy_w[i] == 1'b0, "R8 ready one cycle", 32'(rdy_w[i]), 0);
            chk(sel_w[i] == 5'd0, "R8 busy strobe ignored", 32'(sel_w[i]), 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(sel_w[i] == 5'd0 && !rdy_w[i] && !err_w[i], "R12 reset idle",
                {sel_w[i], rdy_w[i], err_w[i]}, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(sel_w[i] == 5'd0 && !rdy_w[i], "R12 idle after reset", 32'(sel_w[i]), 0);
        end
        // R1 every window, word reads
        txn(16'h2000, 0, 1, 0, 0);
        txn(16'h5FFE, 0, 1, 0, 0);
        txn(16'h6A42, 0, 1, 0, 0);
        txn(16'hA010, 0, 1, 0, 0);
        txn(16'hDFFE, 0, 1, 0, 0);
        // R2/R3 gaps: fault in full mode, alias in partial mode
        txn(16'h0000, 0, 1, 0, 0);
        txn(16'h1FFF, 0, 0, 0, 0);
        txn(16'h8000, 0, 1, 0, 0);
        txn(16'hE000, 0, 1, 0, 0);
        txn(16'hFFFF, 0, 0, 0, 0);
        // R7 ROM writes, R6 forwarded writes, R9 byte lanes
        txn(16'h4000, 1, 1, 16'h1234, 0);
        txn(16'hC002, 1, 0, 16'h00AB, 0);
        txn(16'h6001, 1, 0, 16'h55C3, 0);
        txn(16'hA010, 1, 1, 16'hBEEF, 0);
        txn(16'h3FFF, 0, 0, 0, 0);
        txn(16'h3FFE, 0, 0, 0, 0);
        // R10 misaligned word
        txn(16'h2001, 0, 1, 0, 0);
        txn(16'hB003, 1, 1, 16'h7777, 0);
        // R8 strobes while busy
        txn(16'h2100, 0, 1, 0, 1);
        txn(16'h0100, 0, 1, 0, 1);
        txn(16'hA202, 1, 0, 16'h0042, 1);
        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            txn(r[15:0], r[16] & r[17], r[18], 16'($urandom), r[19] & r[20] & r[21]);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule